// File: doc/BRIEF.md
# Phase-Zero SPI Master with Programmable Chip-Select Gaps

This block is a single-word SPI master for clock phase 0. It makes a serial clock, a data-out line and an active-low chip select from the system clock. One pulse on the write strobe starts a word, and a one-cycle completion pulse returns the word shifted in from the slave. Configuration inputs set the clock rate, the idle level of the serial clock, and the gaps between chip select and serial clock. They are captured when a word starts. The clock rate comes from an 8-bit prescale value.

Before the first serial clock edge, the master waits for a programmable setup count of system-clock cycles. It then samples a slave-ready input at a fixed offset from the start. If the slave is not ready, the master keeps sampling every cycle with the serial clock idle. After the last serial clock edge, chip select stays asserted for half a serial clock period plus a programmable hold count. A keep-select option makes the setup gap one cycle longer. It also leaves chip select asserted between words until the option is cleared while the master is idle.

Top module: `spi_cs_master`

## Requirements
- R1: While reset is high and on the first cycle after it, `cs_n` is 1, `busy` is 0, `done` is 0 and `sclk` equals `cfg_cpol`.
- R2: With prescale value PS, one serial clock period lasts P = PS+1 system cycles for PS from 1 to 255 and P = 2 for PS = 0. Each period spends P - floor(P/2) cycles at the active (non-idle) level and floor(P/2) cycles at the idle level.
- R3: `sclk` idles at the level `cfg_cpol`. `miso` is sampled on each edge that leaves the idle level. `mosi` changes only on edges that return to idle. The first bit is present from the cycle the word starts. Bits go out most-significant first.
- R4: Let `busy` rise at cycle F. With the slave ready, the first `sclk` edge is at cycle F + C + 2, where C is `cfg_setup_cnt`. With `cfg_cs_keep` set it is at F + C + 3.
- R5: `slv_rdy` is first sampled at the clock edge F + C + 1 and then on every edge until it is seen high. The first `sclk` edge follows one cycle after that edge, or two cycles with `cfg_cs_keep` set.
- R6: The completion cycle comes floor(P/2) + T + 1 cycles after the last `sclk` edge, where T is `cfg_hold_cnt`.
- R7: `done` is high for exactly one cycle. In that cycle `rd_word` holds the bits taken from `miso`, first bit in the MSB. Without keep-select, `cs_n` rises in that same cycle.
- R8: With `cfg_cs_keep` set, `cs_n` stays 0 after the word. It goes to 1 one cycle after the idle master samples `cfg_cs_keep` low.
- R9: A write strobe while `busy` is high is ignored. The current word's output bits are unchanged, and no further word starts after it.
- R10: `busy` rises the cycle after an accepted write strobe. It falls in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_prescale | input | PRESC_W | Serial clock prescale value |
| cfg_setup_cnt | input | GAP_W | Extra cycles from select to first edge |
| cfg_hold_cnt | input | GAP_W | Extra cycles from last edge to release |
| cfg_cs_keep | input | 1 | Keep chip select asserted between words |
| wr_stb | input | 1 | Start a word (one cycle) |
| wr_word | input | WORD_W | Word to transmit |
| slv_rdy | input | 1 | Slave ready, sampled before the first edge |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | WORD_W | Received word, valid with `done` |

## Verification
The properties assume that reset is held from time zero until the first clock edges. They also assume that `slv_rdy` eventually rises during every word, because a word that never gets a ready slave never completes. The properties compare outputs only across cycles in which `busy` stays high, so a change of `cfg_cpol` while idle cannot be read as a serial clock edge. The stimulus changes configuration only on an idle cycle before each write. It raises the ready input after a bounded random number of cycles, sometimes later than the programmed sample point. It mixes random prescale and gap values with the extremes 0 and 255.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_SHIFT = 2'd2,
    SQ_TAIL  = 2'd3
  } sq_state_t;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_cs_sclkgen.sv
module spi_cs_sclkgen #(
  parameter int PSW = 8,
  localparam int LW = PSW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           idle_lvl,
  input  logic           start,
  input  logic           hold_extra,
  input  logic           run,
  input  logic [PSW-1:0] ps,
  output logic           sclk_q,
  output logic           lead_ev,
  output logic           trail_ev,
  output logic [LW-1:0]  h_idle
);
  logic [LW-1:0] per;
  logic [LW-1:0] h_act;
  logic [LW-1:0] hcnt;
  logic          tick;

  // period and its split: active phase takes the larger half on odd periods
  always_comb begin
    per    = (ps == '0) ? LW'(2) : (LW'(ps) + LW'(1));
    h_idle = per >> 1;
    h_act  = per - h_idle;
  end

  assign tick     = run && (hcnt == '0);
  assign lead_ev  = tick && (sclk_q == idle_lvl);
  assign trail_ev = tick && (sclk_q != idle_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= idle_lvl;
      hcnt   <= '0;
    end else if (start) begin
      sclk_q <= idle_lvl;
      hcnt   <= hold_extra ? LW'(1) : LW'(0);
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      hcnt   <= (lead_ev ? h_act : h_idle) - LW'(1);
    end else if (run) begin
      hcnt   <= hcnt - LW'(1);
    end else begin
      sclk_q <= idle_lvl;
    end
  end
endmodule

// File: rtl/spi_cs_gapcnt.sv
module spi_cs_gapcnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
  parameter int W = 8,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         lead,
  input  logic         trail,
  input  logic         miso,
  output logic         mosi_q,
  output logic [W-1:0] rx_q,
  output logic         last_bit
);
  logic [W-1:0]  tx_sr;
  logic [BW-1:0] nbit;

  assign last_bit = (nbit == BW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr  <= '0;
      rx_q   <= '0;
      nbit   <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_sr  <= data;
      nbit   <= '0;
      mosi_q <= data[W-1];
    end else begin
      if (lead)
        rx_q <= {rx_q[W-2:0], miso};
      if (trail) begin
        tx_sr  <= tx_sr << 1;
        mosi_q <= tx_sr[W-2];
        nbit   <= nbit + BW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int PRESC_W = 8,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_cpol,
  input  logic [PRESC_W-1:0] cfg_prescale,
  input  logic [GAP_W-1:0]   cfg_setup_cnt,
  input  logic [GAP_W-1:0]   cfg_hold_cnt,
  input  logic               cfg_cs_keep,
  input  logic               wr_stb,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               slv_rdy,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               busy,
  output logic               done,
  output logic [WORD_W-1:0]  rd_word
);
  localparam int LW = PRESC_W + 1;
  localparam int CW = max_i(GAP_W, PRESC_W) + 1;

  sq_state_t          state;
  logic               cpol_q;
  logic [PRESC_W-1:0] ps_q;
  logic [GAP_W-1:0]   t2c_q;
  logic               keep_q;

  logic               accept;
  logic               go_shift;
  logic               word_end;
  logic               lead_ev;
  logic               trail_ev;
  logic [LW-1:0]      h_idle;
  logic               gap_zero;
  logic               gap_load;
  logic [CW-1:0]      gap_val;
  logic               last_bit;
  logic [WORD_W-1:0]  rx_bits;
  logic               idle_lvl;

  assign busy     = (state != SQ_IDLE);
  assign idle_lvl = busy ? cpol_q : cfg_cpol;
  assign accept   = (state == SQ_IDLE) && wr_stb;
  assign go_shift = (state == SQ_SETUP) && gap_zero && slv_rdy;
  assign word_end = (state == SQ_SHIFT) && trail_ev && last_bit;
  assign gap_load = accept || word_end;
  assign gap_val  = accept ? CW'(cfg_setup_cnt)
                           : (CW'(h_idle) + CW'(t2c_q));

  spi_cs_sclkgen #(.PSW(PRESC_W)) u_clk (
    .clk        (clk),
    .rst        (rst),
    .idle_lvl   (idle_lvl),
    .start      (go_shift),
    .hold_extra (keep_q),
    .run        (state == SQ_SHIFT),
    .ps         (ps_q),
    .sclk_q     (sclk),
    .lead_ev    (lead_ev),
    .trail_ev   (trail_ev),
    .h_idle     (h_idle)
  );

  spi_cs_gapcnt #(.CW(CW)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  spi_cs_shifter #(.W(WORD_W)) u_sh (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .data     (wr_word),
    .lead     (lead_ev),
    .trail    (trail_ev),
    .miso     (miso),
    .mosi_q   (mosi),
    .rx_q     (rx_bits),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      cs_n    <= 1'b1;
      done    <= 1'b0;
      rd_word <= '0;
      cpol_q  <= 1'b0;
      ps_q    <= '0;
      t2c_q   <= '0;
      keep_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (wr_stb) begin
            state  <= SQ_SETUP;
            cs_n   <= 1'b0;
            cpol_q <= cfg_cpol;
            ps_q   <= cfg_prescale;
            t2c_q  <= cfg_hold_cnt;
            keep_q <= cfg_cs_keep;
          end else if (!cfg_cs_keep) begin
            cs_n <= 1'b1;
          end
        end
        SQ_SETUP: begin
          if (go_shift) state <= SQ_SHIFT;
        end
        SQ_SHIFT: begin
          if (word_end) state <= SQ_TAIL;
        end
        SQ_TAIL: begin
          if (gap_zero) begin
            state   <= SQ_IDLE;
            done    <= 1'b1;
            rd_word <= rx_bits;
            cs_n    <= ~keep_q;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R10

  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);  // R10

  AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && (sclk != $past(sclk))) |-> (!cs_n && !$past(cs_n)));  // R3

  AST_MOSI_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && (mosi != $past(mosi))) |-> (sclk != $past(sclk)));  // R3

  AST_CS_RISE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !busy);  // R6
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .sclk (sclk),
  .mosi (mosi),
  .cs_n (cs_n),
  .busy (busy),
  .done (done)
);

// File: tb/sim_spi_cs_master.sv
module sim_spi_cs_master;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_cpol = 1'b0;
  logic [7:0]   cfg_prescale = '0;
  logic [7:0]   cfg_setup_cnt = '0;
  logic [7:0]   cfg_hold_cnt = '0;
  logic         cfg_cs_keep = 1'b0;
  logic         wr_stb = 1'b0;
  logic [W-1:0] wr_word = '0;
  logic         slv_rdy;
  logic         miso;
  logic         sclk, mosi, cs_n, busy, done;
  logic [W-1:0] rd_word;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // monitor state
  int F, first_t, last_tr, cs_rise, d_t, nl, nt, sbit, thr, nxfer, dbl;
  int lead_t [W];
  int trail_t[W];
  logic [W-1:0] mosi_got, s_word, d_word;
  logic idle_seen, cur_cpol, d_csn, d_busy, d_pbusy;
  logic p_busy, p_sclk, p_csn, p_done;

  spi_cs_master #(.WORD_W(W), .PRESC_W(8), .GAP_W(8)) u0 (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_prescale(cfg_prescale),
    .cfg_setup_cnt(cfg_setup_cnt), .cfg_hold_cnt(cfg_hold_cnt),
    .cfg_cs_keep(cfg_cs_keep), .wr_stb(wr_stb), .wr_word(wr_word),
    .slv_rdy(slv_rdy), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done), .rd_word(rd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // slave model and edge recorder
  always @(negedge clk) begin
    if (rst) begin
      slv_rdy = 1'b0; miso = 1'b0; nxfer = 0; dbl = 0; thr = 0;
      p_busy = 1'b0; p_sclk = sclk; p_csn = 1'b1; p_done = 1'b0;
      cs_rise = -1; F = 0; first_t = -1;
    end else begin
      if (busy && !p_busy) begin
        F = cyc; nl = 0; nt = 0; first_t = -1; idle_seen = sclk;
        sbit = W - 1; miso = s_word[W-1]; mosi_got = '0;
      end
      if (busy && p_busy && (sclk != p_sclk)) begin
        if (first_t < 0) first_t = cyc;
        if (sclk != cur_cpol) begin
          if (nl < W) begin lead_t[nl] = cyc; mosi_got[W-1-nl] = mosi; end
          nl++;
        end else begin
          if (nt < W) trail_t[nt] = cyc;
          nt++;
          last_tr = cyc;
          if (sbit > 0) begin sbit--; miso = s_word[sbit]; end
        end
      end
      if (cs_n && !p_csn) cs_rise = cyc;
      if (done) begin
        if (p_done) dbl++;
        d_t = cyc; d_word = rd_word; d_csn = cs_n; d_busy = busy; d_pbusy = p_busy;
        nxfer++;
      end
      slv_rdy = busy && ((cyc - F) >= thr);
      p_busy = busy; p_sclk = sclk; p_csn = cs_n; p_done = done;
    end
  end

  function automatic int per_of(input int ps);
    return (ps == 0) ? 2 : ps + 1;
  endfunction

  task automatic run_word(input logic [W-1:0] d, input logic [W-1:0] sw,
                          input int ps, input int c2t, input int t2c,
                          input bit pol, input bit keep, input int thr_i,
                          input bit poke);
    int old, wr_c, per, h1, h2, efirst, gap;
    bit ok;
    @(negedge clk);
    cfg_prescale = 8'(ps); cfg_setup_cnt = 8'(c2t); cfg_hold_cnt = 8'(t2c);
    cfg_cpol = pol; cfg_cs_keep = keep; cur_cpol = pol; s_word = sw; thr = thr_i;
    @(negedge clk);
    old = nxfer; wr_c = cyc;
    wr_stb = 1'b1; wr_word = d;
    @(negedge clk);
    wr_stb = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      wr_word = ~d; wr_stb = 1'b1;   // R9: write while busy
      @(negedge clk);
      wr_stb = 1'b0;
    end
    wait (nxfer != old);
    @(negedge clk);
    per = per_of(ps); h2 = per / 2; h1 = per - h2;
    gap = (thr_i > c2t) ? thr_i : c2t;
    efirst = F + gap + 2 + (keep ? 1 : 0);
    chk(F == wr_c + 1, "R10 busy rise", F - wr_c, 1);
    if (thr_i > c2t) chk(first_t == efirst, "R5 first edge after late ready", first_t - F, efirst - F);
    else             chk(first_t == efirst, "R4 first edge after setup", first_t - F, efirst - F);
    chk(idle_seen == pol, "R3 idle level", int'(idle_seen), int'(pol));
    ok = (nl == W) && (nt == W);
    for (int i = 0; i < W; i++) begin
      if (trail_t[i] - lead_t[i] != h1) ok = 0;
      if (i < W - 1 && (lead_t[i+1] - lead_t[i] != per)) ok = 0;
    end
    chk(ok, "R2 sclk period", lead_t[1] - lead_t[0], per);
    chk(mosi_got == d, "R3 mosi bits", int'(mosi_got), int'(d));
    chk(d_word == sw, "R7 received word", int'(d_word), int'(sw));
    chk(d_t == last_tr + h2 + t2c + 1, "R6 tail gap", d_t - last_tr, h2 + t2c + 1);
    chk(dbl == 0, "R7 done width", dbl, 0);
    chk(!d_busy && d_pbusy, "R10 busy fall", int'(d_busy), 0);
    if (keep) chk(d_csn == 1'b0, "R8 select kept", int'(d_csn), 0);
    else      chk(cs_rise == d_t, "R7 select release", cs_rise, d_t);
    if (poke) begin
      old = nxfer;
      repeat (12) begin
        @(negedge clk);
        if (busy) ok = 0;
      end
      chk(!busy && nxfer == old, "R9 write ignored", nxfer - old, 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cfg_cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b1, "R1 idle sclk after reset", int'(sclk), 1);
    chk(cs_n == 1'b1 && !busy, "R1 idle after reset", int'(cs_n), 1);

    // directed corners
    run_word(8'hA5, 8'h3C, 0,   0,   0,   1'b0, 1'b0, 0, 1'b0);
    run_word(8'h81, 8'hF0, 1,   3,   2,   1'b1, 1'b0, 0, 1'b0);
    run_word(8'h5A, 8'h96, 2,   0,   255, 1'b0, 1'b0, 0, 1'b0);
    run_word(8'hC3, 8'h01, 255, 255, 0,   1'b1, 1'b0, 0, 1'b0);
    run_word(8'h7E, 8'h80, 4,   2,   1,   1'b0, 1'b0, 9, 1'b0);
    run_word(8'h0F, 8'hAA, 3,   1,   3,   1'b1, 1'b0, 0, 1'b1);
    run_word(8'h33, 8'h55, 5,   2,   4,   1'b0, 1'b1, 0, 1'b0);
    run_word(8'hCC, 8'h99, 0,   0,   0,   1'b0, 1'b1, 5, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk(cs_n == 1'b0, "R8 select held while idle", int'(cs_n), 0);
    end
    cfg_cs_keep = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R8 select released", int'(cs_n), 1);

    // constrained random
    for (int k = 0; k < 24; k++) begin
      int ps, c2t, t2c, th;
      ps  = (k % 4 == 0) ? int'($urandom % 256) : int'($urandom % 6);
      c2t = (k % 3 == 0) ? int'($urandom % 256) : int'($urandom % 5);
      t2c = (k % 5 == 0) ? int'($urandom % 256) : int'($urandom % 5);
      th  = int'($urandom % 8);
      run_word(W'($urandom), W'($urandom), ps, c2t, t2c,
               1'($urandom), 1'($urandom), th, (k % 6 == 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule